// File: doc/BRIEF.md
# USB Link Reset, Suspend and Remote-Wakeup Timer

This block watches the decoded line state of a full-speed USB device and turns it into link power events. It runs the clock-based timing that a device controller needs around the bus. It reports a bus reset when the line holds single-ended zero long enough. It reports entry into suspend after a long idle (J) stretch. It can switch the local oscillator off a fixed time after suspend begins. It drives the K state for resume signalling when firmware asks for remote wakeup.

The local clock runs at either 12 MHz or 6 MHz, picked by a select input. All thresholds are given in half-microsecond units and scaled to cycles: 6 cycles per unit at 12 MHz and 3 at 6 MHz. The defaults match 2.5 µs for reset, 3 ms for suspend, 2 ms for oscillator stop, 5 ms for the wakeup idle guard and 10 ms for resume drive. A wakeup request that comes before the line has been idle for the guard time is held back until the guard time is met.

Top module: `usb_link_pm`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `bus_reset_pulse`, `suspend_pulse`, `osc_stop` and `drive_k` are all 0.
- R2: Line code 2'b00 is SE0. When SE0 holds for at least RESET_HT×P cycles (P = 6 when `fast_clk_sel` is 1, P = 3 when it is 0), `bus_reset_pulse` is high for exactly one cycle. It fires once per unbroken SE0 run. A shorter run, or one broken by any other code, gives no pulse.
- R3: Line code 2'b01 is idle (J). When J holds for at least SUSP_HT×P cycles, `suspend_pulse` is high for exactly one cycle and the block enters suspend. The pulse fires once per unbroken J run. Codes 2'b10 (K) and 2'b11 are bus activity: they restart the idle run and never give a suspend pulse.
- R4: The cycle thresholds in R2, R3, R5, R8 and R9 halve when `fast_clk_sel` is 0 compared to 1.
- R5: With `osc_stop_en` high, `osc_stop` rises exactly OSCOFF_HT×P cycles after the cycle in which `suspend_pulse` is high, provided the line stays J.
- R6: With `osc_stop_en` low, `osc_stop` stays 0 through suspend.
- R7: Any non-J code while suspended ends suspend. `osc_stop` falls in the second cycle after the input changes.
- R8: A remote wakeup starts only while suspended, `wake_req` is high, and the idle run has reached WAKE_HT×P cycles. If `wake_req` is already high, `drive_k` rises exactly (WAKE_HT−SUSP_HT)×P cycles after the suspend pulse. If `wake_req` rises after that point, `drive_k` rises in the next cycle.
- R9: `drive_k` stays high for exactly RESUME_HT×P cycles and then falls. `osc_stop` is 0 from the cycle `drive_k` rises.
- R10: `wake_req` has no effect outside suspend. `drive_k` stays 0 while the block is awake, including after a resume has finished with the line still idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock (6 or 12 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| line_state | input | 2 | Decoded line: 00 SE0, 01 J, 10 K, 11 SE1 |
| fast_clk_sel | input | 1 | 1 = 12 MHz time base, 0 = 6 MHz |
| osc_stop_en | input | 1 | Allow oscillator shutdown during suspend |
| wake_req | input | 1 | Remote wakeup request (level) |
| bus_reset_pulse | output | 1 | One-cycle bus reset event |
| suspend_pulse | output | 1 | One-cycle suspend entry event |
| osc_stop | output | 1 | Oscillator stop control |
| drive_k | output | 1 | Drive K on the bus for resume |

## Verification
The assertions check several properties on every cycle. Both event pulses last one cycle. A suspend pulse only follows an idle line. The oscillator only stops when the enable was set. Bus activity during suspend always restarts the oscillator. A rise of `drive_k` is always preceded by a request and a long idle stretch. The exact threshold lengths can only be shown by the bench's scenarios. These include the one-cycle-short and exact-length runs at both clock rates, the delay from suspend to oscillator stop, deferred and late wakeups, the resume width, and requests that must be ignored.

// File: rtl/usb_link_pm_pkg.sv
package usb_link_pm_pkg;

    // Decoded line codes; the encoding is part of the block's interface.
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        PM_AWAKE,
        PM_SUSP,
        PM_OSC_OFF,
        PM_RESUME
    } pm_e;

    // Events produced by the line timers for the power sequencer.
    typedef struct packed {
        logic reset_pulse;
        logic suspend_pulse;
        logic suspend_hit;
        logic long_idle;
        logic line_idle;
    } line_ev_t;

    function automatic int unsigned ht_cycles(input int unsigned ht, input int unsigned per_ht);
        return ht * per_ht;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/lpm_line_timers.sv
module lpm_line_timers
    import usb_link_pm_pkg::*;
#(
    parameter int unsigned SE0_W  = 8,
    parameter int unsigned IDLE_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        line_state,
    input  logic [SE0_W-1:0]  thr_rst,
    input  logic [IDLE_W-1:0] thr_susp,
    input  logic [IDLE_W-1:0] thr_wake,
    output line_ev_t          ev
);

    line_e             ls_q;
    logic [SE0_W-1:0]  se0_len;
    logic [IDLE_W-1:0] idle_len;
    logic              se0_on;
    logic              idle_on;
    logic              se0_hit;
    logic              susp_hit;
    logic              rst_pulse_q;
    logic              susp_pulse_q;

    // One sampling stage; reset value counts as activity so no run starts early.
    always_ff @(posedge clk) begin
        if (rst) ls_q <= LS_K;
        else     ls_q <= line_e'(line_state);
    end

    assign se0_on  = (ls_q == LS_SE0);
    assign idle_on = (ls_q == LS_J);

    // Run lengths saturate at the largest threshold they are compared with.
    always_ff @(posedge clk) begin
        if (rst || !se0_on)          se0_len <= '0;
        else if (se0_len < thr_rst)  se0_len <= se0_len + SE0_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !idle_on)           idle_len <= '0;
        else if (idle_len < thr_wake)  idle_len <= idle_len + IDLE_W'(1);
    end

    // A hit marks the edge that completes the threshold-th cycle of a run.
    assign se0_hit  = se0_on  && (se0_len  == thr_rst  - SE0_W'(1));
    assign susp_hit = idle_on && (idle_len == thr_susp - IDLE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_pulse_q  <= 1'b0;
            susp_pulse_q <= 1'b0;
        end else begin
            rst_pulse_q  <= se0_hit;
            susp_pulse_q <= susp_hit;
        end
    end

    always_comb begin
        ev.reset_pulse   = rst_pulse_q;
        ev.suspend_pulse = susp_pulse_q;
        ev.suspend_hit   = susp_hit;
        ev.long_idle     = idle_on && (idle_len >= thr_wake - IDLE_W'(1));
        ev.line_idle     = idle_on;
    end

    // R2: bus reset event lasts a single cycle
    a_r2_reset_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rst_pulse_q |=> !rst_pulse_q);

    // R3: suspend event lasts a single cycle
    a_r3_suspend_one_cycle: assert property (@(posedge clk) disable iff (rst)
        susp_pulse_q |=> !susp_pulse_q);

    // R3: suspend event only follows an idle line sample
    a_r3_suspend_after_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(susp_pulse_q) |-> $past(idle_on));

endmodule

// File: rtl/lpm_power_fsm.sv
module lpm_power_fsm
    import usb_link_pm_pkg::*;
#(
    parameter int unsigned TMR_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             suspend_hit,
    input  logic             long_idle,
    input  logic             line_idle,
    input  logic             osc_stop_en,
    input  logic             wake_req,
    input  logic [TMR_W-1:0] thr_osc,
    input  logic [TMR_W-1:0] thr_k,
    output logic             osc_stop,
    output logic             drive_k
);

    pm_e              state_q, state_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic             suspended;

    assign suspended = (state_q == PM_SUSP) || (state_q == PM_OSC_OFF);

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        unique case (state_q)
            PM_AWAKE: begin
                if (suspend_hit) begin
                    state_d = PM_SUSP;
                    tmr_d   = '0;
                end
            end
            PM_SUSP, PM_OSC_OFF: begin
                if (!line_idle) begin
                    state_d = PM_AWAKE;
                end else if (wake_req && long_idle) begin
                    state_d = PM_RESUME;
                    tmr_d   = '0;
                end else if (state_q == PM_SUSP) begin
                    if (osc_stop_en && (tmr_q == thr_osc - TMR_W'(1))) begin
                        state_d = PM_OSC_OFF;
                    end else if (tmr_q < thr_osc - TMR_W'(1)) begin
                        tmr_d = tmr_q + TMR_W'(1);
                    end
                end
            end
            PM_RESUME: begin
                if (tmr_q == thr_k - TMR_W'(1)) state_d = PM_AWAKE;
                else                            tmr_d   = tmr_q + TMR_W'(1);
            end
            default: state_d = PM_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_AWAKE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    assign osc_stop = (state_q == PM_OSC_OFF);
    assign drive_k  = (state_q == PM_RESUME);

    // R6: the oscillator is only stopped when shutdown was allowed
    a_r6_stop_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_stop) |-> $past(osc_stop_en));

    // R7: bus activity seen with the oscillator off restarts it next cycle
    a_r7_activity_restarts: assert property (@(posedge clk) disable iff (rst)
        (osc_stop && !line_idle) |=> !osc_stop);

    // R8: resume drive needs a request and a long idle stretch
    a_r8_wake_qualified: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_k) |-> ($past(wake_req) && $past(long_idle)));

    // R10: resume drive only ever starts from suspend
    a_r10_wake_from_suspend: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_k) |-> $past(suspended));

endmodule

// File: rtl/usb_link_pm.sv
module usb_link_pm
    import usb_link_pm_pkg::*;
#(
    parameter int unsigned RESET_HT        = 5,
    parameter int unsigned SUSP_HT         = 6000,
    parameter int unsigned OSCOFF_HT       = 4000,
    parameter int unsigned WAKE_HT         = 10000,
    parameter int unsigned RESUME_HT       = 20000,
    parameter int unsigned CYC_PER_HT_FAST = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_state,
    input  logic       fast_clk_sel,
    input  logic       osc_stop_en,
    input  logic       wake_req,
    output logic       bus_reset_pulse,
    output logic       suspend_pulse,
    output logic       osc_stop,
    output logic       drive_k
);

    localparam int unsigned CYC_PER_HT_SLOW = CYC_PER_HT_FAST / 2;

    localparam int unsigned RST_F  = ht_cycles(RESET_HT,  CYC_PER_HT_FAST);
    localparam int unsigned RST_S  = ht_cycles(RESET_HT,  CYC_PER_HT_SLOW);
    localparam int unsigned SUSP_F = ht_cycles(SUSP_HT,   CYC_PER_HT_FAST);
    localparam int unsigned SUSP_S = ht_cycles(SUSP_HT,   CYC_PER_HT_SLOW);
    localparam int unsigned WAKE_F = ht_cycles(WAKE_HT,   CYC_PER_HT_FAST);
    localparam int unsigned WAKE_S = ht_cycles(WAKE_HT,   CYC_PER_HT_SLOW);
    localparam int unsigned OSC_F  = ht_cycles(OSCOFF_HT, CYC_PER_HT_FAST);
    localparam int unsigned OSC_S  = ht_cycles(OSCOFF_HT, CYC_PER_HT_SLOW);
    localparam int unsigned K_F    = ht_cycles(RESUME_HT, CYC_PER_HT_FAST);
    localparam int unsigned K_S    = ht_cycles(RESUME_HT, CYC_PER_HT_SLOW);

    localparam int unsigned SE0_W  = cnt_width(RST_F);
    localparam int unsigned IDLE_W = cnt_width(WAKE_F);
    localparam int unsigned TMR_W  = cnt_width((OSC_F > K_F) ? OSC_F : K_F);

    logic [SE0_W-1:0]  thr_rst;
    logic [IDLE_W-1:0] thr_susp;
    logic [IDLE_W-1:0] thr_wake;
    logic [TMR_W-1:0]  thr_osc;
    logic [TMR_W-1:0]  thr_k;
    line_ev_t          ev;

    // Time-base select scales every threshold together.
    assign thr_rst  = fast_clk_sel ? SE0_W'(RST_F)   : SE0_W'(RST_S);
    assign thr_susp = fast_clk_sel ? IDLE_W'(SUSP_F) : IDLE_W'(SUSP_S);
    assign thr_wake = fast_clk_sel ? IDLE_W'(WAKE_F) : IDLE_W'(WAKE_S);
    assign thr_osc  = fast_clk_sel ? TMR_W'(OSC_F)   : TMR_W'(OSC_S);
    assign thr_k    = fast_clk_sel ? TMR_W'(K_F)     : TMR_W'(K_S);

    lpm_line_timers #(
        .SE0_W  (SE0_W),
        .IDLE_W (IDLE_W)
    ) u_lines (
        .clk        (clk),
        .rst        (rst),
        .line_state (line_state),
        .thr_rst    (thr_rst),
        .thr_susp   (thr_susp),
        .thr_wake   (thr_wake),
        .ev         (ev)
    );

    lpm_power_fsm #(
        .TMR_W (TMR_W)
    ) u_pm (
        .clk         (clk),
        .rst         (rst),
        .suspend_hit (ev.suspend_hit),
        .long_idle   (ev.long_idle),
        .line_idle   (ev.line_idle),
        .osc_stop_en (osc_stop_en),
        .wake_req    (wake_req),
        .thr_osc     (thr_osc),
        .thr_k       (thr_k),
        .osc_stop    (osc_stop),
        .drive_k     (drive_k)
    );

    assign bus_reset_pulse = ev.reset_pulse;
    assign suspend_pulse   = ev.suspend_pulse;

    // R9: resume drive and oscillator stop never overlap
    a_r9_no_stop_while_k: assert property (@(posedge clk) disable iff (rst)
        drive_k |-> !osc_stop);

endmodule

// File: tb/sim_usb_link_pm.sv
module sim_usb_link_pm;

    localparam int CLK_PERIOD = 10;
    localparam int Q = CLK_PERIOD / 4;

    // Scaled-down thresholds in half-microsecond units.
    // Fast (P=6): reset 30, suspend 240, osc 120, wake 360, resume 180 cycles.
    // Slow (P=3): reset 15, suspend 120, osc 60,  wake 180, resume 90 cycles.
    localparam int unsigned RESET_HT = 5, SUSP_HT = 40, OSCOFF_HT = 20, WAKE_HT = 60, RESUME_HT = 30;

    typedef struct packed {
        logic        sel;
        logic [1:0]  ls;
        logic [15:0] len;
        logic [3:0]  exp_rst;
        logic [3:0]  exp_susp;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{1'b1, 2'b00, 16'd29,  4'd0, 4'd0},   // R2 fast, one short
        '{1'b1, 2'b00, 16'd30,  4'd1, 4'd0},   // R2 fast, exact
        '{1'b1, 2'b00, 16'd100, 4'd1, 4'd0},   // R2 long run fires once
        '{1'b0, 2'b00, 16'd14,  4'd0, 4'd0},   // R4 slow, one short
        '{1'b0, 2'b00, 16'd15,  4'd1, 4'd0},   // R4 slow, exact
        '{1'b1, 2'b01, 16'd239, 4'd0, 4'd0},   // R3 fast, one short
        '{1'b1, 2'b01, 16'd240, 4'd0, 4'd1},   // R3 fast, exact
        '{1'b0, 2'b01, 16'd119, 4'd0, 4'd0},   // R4 slow, one short
        '{1'b0, 2'b01, 16'd120, 4'd0, 4'd1},   // R4 slow, exact
        '{1'b1, 2'b11, 16'd300, 4'd0, 4'd0},   // R3 SE1 is activity
        '{1'b1, 2'b10, 16'd300, 4'd0, 4'd0}    // R3 K is activity
    };

    logic clk = 1'b0;
    logic rst;
    logic [1:0] line_state;
    logic fast_clk_sel, osc_stop_en, wake_req;
    logic bus_reset_pulse, suspend_pulse, osc_stop, drive_k;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int n_rst = 0, n_susp = 0, n_oscr = 0, n_kr = 0;
    int t_susp = 0, t_osc_rise = 0, t_osc_fall = 0, t_k_rise = 0, t_k_fall = 0;
    logic p_osc = 1'b0, p_k = 1'b0;

    usb_link_pm #(
        .RESET_HT(RESET_HT), .SUSP_HT(SUSP_HT), .OSCOFF_HT(OSCOFF_HT),
        .WAKE_HT(WAKE_HT), .RESUME_HT(RESUME_HT), .CYC_PER_HT_FAST(6)
    ) u0 (
        .clk(clk), .rst(rst), .line_state(line_state), .fast_clk_sel(fast_clk_sel),
        .osc_stop_en(osc_stop_en), .wake_req(wake_req),
        .bus_reset_pulse(bus_reset_pulse), .suspend_pulse(suspend_pulse),
        .osc_stop(osc_stop), .drive_k(drive_k)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Event monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (bus_reset_pulse) n_rst <= n_rst + 1;
        if (suspend_pulse) begin n_susp <= n_susp + 1; t_susp <= cyc; end
        if (osc_stop && !p_osc) begin n_oscr <= n_oscr + 1; t_osc_rise <= cyc; end
        if (!osc_stop && p_osc) t_osc_fall <= cyc;
        if (drive_k && !p_k) begin n_kr <= n_kr + 1; t_k_rise <= cyc; end
        if (!drive_k && p_k) t_k_fall <= cyc;
        p_osc <= osc_stop;
        p_k   <= drive_k;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
        $finish;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Change the line after an edge and hold it for n cycles.
    task automatic hold(input logic [1:0] ls, input int n);
        @(posedge clk); #(Q);
        line_state = ls;
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int b_rst, b_susp, b_oscr, b_kr, c_set;
        rst = 1'b1; line_state = 2'b10; fast_clk_sel = 1'b1; osc_stop_en = 1'b0; wake_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "outputs in reset", {bus_reset_pulse, suspend_pulse, osc_stop, drive_k}, 0);
        @(posedge clk); #(Q); rst = 1'b0;
        @(negedge clk);
        check("R1", "outputs after release", {bus_reset_pulse, suspend_pulse, osc_stop, drive_k}, 0);

        // Vector table: run lengths around each threshold.
        for (int i = 0; i < 11; i++) begin
            fast_clk_sel = VEC[i].sel; osc_stop_en = 1'b0; wake_req = 1'b0;
            hold(2'b10, 4);
            settle(2);
            b_rst = n_rst; b_susp = n_susp;
            hold(VEC[i].ls, int'(VEC[i].len));
            hold(2'b10, 4);
            settle(2);
            check("R2", $sformatf("vector %0d reset pulses", i), n_rst - b_rst, int'(VEC[i].exp_rst));
            check("R3", $sformatf("vector %0d suspend pulses", i), n_susp - b_susp, int'(VEC[i].exp_susp));
        end

        // R2/R3: one-cycle breaks restart the runs.
        fast_clk_sel = 1'b1;
        b_rst = n_rst; b_susp = n_susp;
        hold(2'b00, 20); hold(2'b01, 1); hold(2'b00, 20);
        hold(2'b01, 200); hold(2'b10, 1); hold(2'b01, 200);
        hold(2'b10, 4); settle(2);
        check("R2", "broken SE0 run pulses", n_rst - b_rst, 0);
        check("R3", "broken idle run pulses", n_susp - b_susp, 0);

        // R5 then R7: oscillator stop timing and restart on K.
        fast_clk_sel = 1'b1; osc_stop_en = 1'b1;
        b_oscr = n_oscr;
        hold(2'b01, 400);
        settle(0);
        check("R5", "osc_stop level in suspend", osc_stop, 1);
        check("R5", "suspend-to-stop delay", t_osc_rise - t_susp, 120);
        @(posedge clk); #(Q); line_state = 2'b10; c_set = cyc;
        settle(4);
        check("R7", "osc_stop fall cycle", t_osc_fall, c_set + 2);
        check("R7", "osc_stop after activity", osc_stop, 0);

        // R6: shutdown disabled, slow clock.
        fast_clk_sel = 1'b0; osc_stop_en = 1'b0;
        b_oscr = n_oscr; b_susp = n_susp;
        hold(2'b01, 400);
        settle(0);
        check("R6", "suspend entered", n_susp - b_susp, 1);
        check("R6", "osc rises with enable low", n_oscr - b_oscr, 0);
        hold(2'b10, 4);

        // R8/R9: early request, deferred to the wake guard.
        fast_clk_sel = 1'b1; osc_stop_en = 1'b0; wake_req = 1'b1;
        b_kr = n_kr;
        hold(2'b01, 700);
        settle(0);
        check("R8", "deferred K rises", n_kr - b_kr, 1);
        check("R8", "suspend-to-K delay", t_k_rise - t_susp, 120);
        check("R9", "K width fast", t_k_fall - t_k_rise, 180);
        // R10: still requesting, awake, line idle: no second resume.
        check("R10", "no re-trigger after resume", n_kr - b_kr, 1);
        wake_req = 1'b0;
        hold(2'b10, 4);

        // R8/R9: late request at slow clock with oscillator off.
        fast_clk_sel = 1'b0; osc_stop_en = 1'b1;
        hold(2'b01, 300);
        settle(0);
        check("R5", "osc off before late wake", osc_stop, 1);
        @(posedge clk); #(Q); wake_req = 1'b1; c_set = cyc;
        settle(120);
        check("R8", "late request K rise", t_k_rise, c_set + 1);
        check("R9", "osc restart at K rise", t_osc_fall, c_set + 1);
        check("R9", "K width slow", t_k_fall - t_k_rise, 90);
        wake_req = 1'b0;
        hold(2'b10, 4);

        // R10: request while awake with short idle runs.
        fast_clk_sel = 1'b1; osc_stop_en = 1'b0; wake_req = 1'b1;
        b_kr = n_kr;
        hold(2'b01, 100); hold(2'b10, 3); hold(2'b01, 100); hold(2'b00, 10);
        settle(2);
        check("R10", "K rises while awake", n_kr - b_kr, 0);
        check("R10", "drive_k level awake", drive_k, 0);
        wake_req = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule